// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides whether each incoming frame is kept or dropped. It compares the first six bytes of the frame, the destination address, against a programmable station address and against the all-ones broadcast address. Two mode bits select which of these two matches may admit a frame. The verdict is registered and held so that downstream logic can act on it before the payload ends.

The same stream also drives a byte counter. The counter is compared with a programmable maximum frame length, and a frame that runs past the limit raises a length-error flag. Software sets up the station address, the mode bits and the length limit through a small write port.

Top module: `rx_addr_filter`

## Requirements
- R1: Writing register select 0 loads the upper station word. Bits 15:8 are destination byte 0, the first byte on the wire. Bits 7:0 are destination byte 1.
- R2: Writing register select 1 loads the lower station word. Bits 31:24, 23:16, 15:8 and 7:0 are destination bytes 2, 3, 4 and 5 in that order.
- R3: Writing register select 2 loads the mode register. When mode bit 3 is set, a frame whose six destination bytes are all 8'hFF is accepted.
- R4: When mode bit 1 is set, a frame whose six destination bytes equal the station address is accepted.
- R5: A frame is accepted only when at least one enabled condition matches. Otherwise it is dropped (`accept` low), including when both mode bits are clear.
- R6: `verdict_valid` and `accept` take their new values in the cycle after the byte at position 5 (the sixth byte) is taken. They do not do so earlier in the frame.
- R7: Once given, the verdict holds until the next start-of-frame byte is taken. That byte clears it one cycle later.
- R8: Writing register select 3 loads the maximum length from `reg_wdata[15:0]`. After reset the limit is 1518.
- R9: `len_err` rises in the cycle after the byte count of the current frame first exceeds the limit. It stays set to the end of the frame and is cleared by the next start-of-frame byte.
- R10: A frame that ends before its sixth byte gets a drop verdict (`verdict_valid` high, `accept` low) in the cycle after its last byte.
- R11: Register writes take effect from the cycle after `reg_we` is sampled. All registers other than the length limit reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 upper addr, 1 lower addr, 2 mode, 3 max length |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| verdict_valid | output | 1 | Decision for the current frame is available |
| accept | output | 1 | Frame accepted (meaningful with verdict_valid) |
| len_err | output | 1 | Current frame exceeded the maximum length |

## Verification
The filter verdict and the length error can both change in the same cycle. This happens when the limit is programmed to 5, so the sixth byte both completes the destination address and pushes the count past the limit. The bench runs such a frame and checks, at the same sample point, that `verdict_valid` has just risen with the right `accept` value and that `len_err` has risen as well. A sample one byte earlier must show neither change. The bench also sweeps all four mode settings against station, broadcast and single-byte-mismatch addresses.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int LEN_W = 16,
  parameter logic [LEN_W-1:0] MAX_LEN_RST = LEN_W'(1518)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        verdict_valid,
  output logic        accept,
  output logic        len_err
);

  localparam int DA_BYTES = 6;

  logic [15:0]      sta_hi;
  logic [31:0]      sta_lo;
  logic             own_en, bc_en;
  logic [LEN_W-1:0] max_len;
  logic [LEN_W-1:0] cnt;
  logic             own_run, bc_run;

  wire [47:0]      sta     = {sta_hi, sta_lo};
  wire [LEN_W-1:0] cur_idx = in_sof ? '0 : cnt;
  wire [LEN_W-1:0] nxt_cnt = (&cur_idx) ? cur_idx : cur_idx + 1'b1;
  wire             in_da   = cur_idx < LEN_W'(DA_BYTES);
  wire             last_da = cur_idx == LEN_W'(DA_BYTES - 1);

  logic [7:0] sta_byte;
  always_comb begin
    case (cur_idx[2:0])
      3'd0:    sta_byte = sta[47:40];
      3'd1:    sta_byte = sta[39:32];
      3'd2:    sta_byte = sta[31:24];
      3'd3:    sta_byte = sta[23:16];
      3'd4:    sta_byte = sta[15:8];
      default: sta_byte = sta[7:0];
    endcase
  end

  wire own_now = (in_sof | own_run) & (in_data == sta_byte);
  wire bc_now  = (in_sof | bc_run)  & (in_data == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_hi  <= '0;
      sta_lo  <= '0;
      own_en  <= 1'b0;
      bc_en   <= 1'b0;
      max_len <= MAX_LEN_RST;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: sta_hi  <= reg_wdata[15:0];
        2'd1: sta_lo  <= reg_wdata;
        2'd2: begin
          own_en <= reg_wdata[1];
          bc_en  <= reg_wdata[3];
        end
        default: max_len <= reg_wdata[LEN_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= '0;
      own_run       <= 1'b0;
      bc_run        <= 1'b0;
      verdict_valid <= 1'b0;
      accept        <= 1'b0;
      len_err       <= 1'b0;
    end else if (in_valid) begin
      cnt     <= nxt_cnt;
      len_err <= (len_err & ~in_sof) | (nxt_cnt > max_len);
      if (in_da) begin
        own_run <= own_now;
        bc_run  <= bc_now;
      end
      if (in_sof) begin
        verdict_valid <= 1'b0;
        accept        <= 1'b0;
      end
      if (last_da) begin
        verdict_valid <= 1'b1;
        accept        <= (own_en & own_now) | (bc_en & bc_now);
      end else if (in_eof && in_da) begin
        verdict_valid <= 1'b1;
        accept        <= 1'b0;
      end
    end
  end

endmodule

module rx_addr_filter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_sof,
  input logic             in_eof,
  input logic             verdict_valid,
  input logic             accept,
  input logic             len_err,
  input logic             own_en,
  input logic             bc_en,
  input logic [LEN_W-1:0] max_len
);

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid && !(in_valid && in_sof) |=> verdict_valid && $stable(accept));

  // R7
  verdict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && !in_eof |=> !verdict_valid);

  // R5
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept) |-> $past(own_en || bc_en));

  // R5
  accept_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> verdict_valid);

  // R9
  len_err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && max_len != '0 |=> !len_err);

endmodule

bind rx_addr_filter rx_addr_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_eof(in_eof), .verdict_valid(verdict_valid), .accept(accept),
  .len_err(len_err), .own_en(own_en), .bc_en(bc_en), .max_len(max_len)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        verdict_valid, accept, len_err;

  int checks = 0, failures = 0;
  int maxl = 1518;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .verdict_valid(verdict_valid),
    .accept(accept), .len_err(len_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] da, input int len, input logic exp_acc, input string tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i > 0)
        chk(len_err == (i > maxl), {"R9 len_err mid ", tag}, len_err, int'(i > maxl));
      if (i == 5)
        chk(verdict_valid == 1'b0, {"R6 early verdict ", tag}, verdict_valid, 0);
      if (i == 6) begin
        chk(verdict_valid == 1'b1, {"R6 verdict ", tag}, verdict_valid, 1);
        chk(accept == exp_acc, {"R5 accept ", tag}, accept, exp_acc);
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(verdict_valid == 1'b1, {"R10 verdict at end ", tag}, verdict_valid, 1);
    chk(accept == ((len >= 6) ? exp_acc : 1'b0), {"R10 accept at end ", tag}, accept,
        (len >= 6) ? exp_acc : 0);
    chk(len_err == (len > maxl), {"R9 len_err at end ", tag}, len_err, int'(len > maxl));
    repeat (2) @(negedge clk);
    chk(verdict_valid == 1'b1 && accept == ((len >= 6) ? exp_acc : 1'b0),
        {"R7 verdict held ", tag}, accept, (len >= 6) ? exp_acc : 0);
  endtask

  localparam logic [47:0] STA = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(verdict_valid == 0 && accept == 0 && len_err == 0, "R11 reset outputs",
        {verdict_valid, accept, len_err}, 0);

    // R8: default limit 1518, mode zero so nothing is accepted
    run_frame(BC, 1518, 1'b0, "R8 len 1518");
    run_frame(BC, 1519, 1'b0, "R8 len 1519");

    // R1 R2 R11: program station address
    wr(2'd0, 32'h0000_0A1B);
    wr(2'd1, 32'h2C3D_4E5F);

    for (int m = 0; m < 4; m++) begin
      wr(2'd2, {28'd0, m[1], 1'b0, m[0], 1'b0});
      run_frame(STA, 10, m[0], $sformatf("R4 own mode=%0d", m));
      run_frame(BC, 10, m[1], $sformatf("R3 bcast mode=%0d", m));
      for (int p = 0; p < 6; p++) begin
        run_frame(STA ^ (48'h01 << (8*(5-p))), 10, 1'b0,
                  $sformatf("%s own miss byte=%0d mode=%0d", (p < 2) ? "R1" : "R2", p, m));
        run_frame(BC ^ (48'h80 << (8*(5-p))), 10, 1'b0,
                  $sformatf("R3 bcast miss byte=%0d mode=%0d", p, m));
      end
    end

    // R10: short frame with both modes on
    wr(2'd2, 32'h0000_000A);
    run_frame(STA, 3, 1'b0, "R10 short");
    run_frame(STA, 1, 1'b0, "R10 single byte");

    // R8 R9: verdict and length error in the same cycle
    wr(2'd3, 32'd5);
    maxl = 5;
    run_frame(STA, 6, 1'b1, "R9 limit 5 len 6");
    run_frame(BC, 5, 1'b1, "R9 limit 5 len 5");
    wr(2'd3, 32'd8);
    maxl = 8;
    run_frame(STA, 8, 1'b1, "R9 limit 8 len 8");
    run_frame(STA, 12, 1'b1, "R9 limit 8 len 12");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule